// File: doc/BRIEF.md
# Radio Power-Mode Enable Sequencer

This controller steps a radio transceiver between a power-down state and its two active modes, transmit and receive. It drives six enable lines (oscillator, clock output, DC offset compensation, peak detector, data detection and power amplifier) and a ready flag. Each line rises only after a programmable delay has passed. Every delay is a parameter counted in pulses of an input time-base strobe `tb_tick`. The defaults assume one pulse every 100 µs, so they match typical startup times of 0.5, 1.1, 2.2, 2.6 and 8 ms.

The active-low `sleep_n` pin selects the state. While it is sampled low the block is active, in the mode chosen by `mode_tx` (1 = transmit, 0 = receive). While it is sampled high the block is in power-down. The value of `sleep_n` at the first clock edge after reset chooses the start path. A start directly into active mode must also wait out a long system settling delay before the ready flag rises. A start in power-down skips that delay.

Setting `keep_clk` keeps the oscillator and the clock output running through power-down. Switching between transmit and receive while active repeats only the target mode's own delays.

Top module: `pwrseq_ctrl`

## Requirements
- R1: If `sleep_n` is sampled high at the first edge after reset, the block stays in power-down. With `keep_clk` low, every output is 0 until `sleep_n` is sampled low.
- R2: `osc_en` is 1 exactly when the registered state is active (`sleep_n` sampled low at the previous edge) or `keep_clk` is 1.
- R3: `clkout_en` rises once `T_CLK` ticks have been counted while `osc_en` is high. It stays high while `osc_en` stays high, which includes power-down when `keep_clk` is 1.
- R4: On the edge where `sleep_n` is sampled high, all mode enables and `seq_ready` drop. `osc_en` and `clkout_en` drop with them unless `keep_clk` is 1.
- R5: In transmit mode (`mode_tx`=1), `pa_en` rises after `T_TX` ticks counted from the point where the clock output is ready. `pa_en` is never 1 in receive mode.
- R6: In receive mode (`mode_tx`=0), `dcoc_en` is 1 from the start of receive setup. `pkdet_en` rises after `T_RX` ticks of receive setup.
- R7: In receive mode, `ddet_en` rises after `T_DD` ticks of receive setup. It is never 1 in transmit mode.
- R8: A change of `mode_tx` while active restarts only the mode delays. `osc_en` and `clkout_en` stay high throughout.
- R9: `seq_ready` is 1 only when the current mode's last enable is up (`pa_en` for transmit, `ddet_en` for receive). After a start into active mode from reset, it also requires that `T_SYS` ticks have passed since reset. It clears on any mode change or on entry to power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Power-down request, active low (low = run) |
| mode_tx | input | 1 | Mode select: 1 transmit, 0 receive |
| keep_clk | input | 1 | Keep oscillator and clock output on during power-down |
| tb_tick | input | 1 | Time-base strobe, one cycle wide |
| osc_en | output | 1 | Oscillator enable |
| clkout_en | output | 1 | Clock output enable |
| dcoc_en | output | 1 | DC offset compensation enable |
| pkdet_en | output | 1 | Peak detector enable |
| ddet_en | output | 1 | Data detection enable |
| pa_en | output | 1 | Power amplifier enable |
| seq_ready | output | 1 | Current mode fully set up |

## Verification
The bound checker checks the ordering relations on every cycle:
- The clock output never runs without the oscillator.
- Data detection implies the peak detector and offset compensation.
- Transmit and receive enables never overlap.
- The ready flag implies the mode's last enable.
- A power-down request clears the mode enables on the next cycle.
- An active request keeps the oscillator and clock output running.

The exact delay lengths, the extra settling delay after an active start from reset, and the restart of the mode delays on a mode switch show only in the bench's scenarios. The bench compares them each clock against its reference model.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic { ST_SLEEP = 1'b0, ST_RUN = 1'b1 } pwr_state_t;
  typedef enum logic { MODE_RX = 1'b0, MODE_TX = 1'b1 } radio_mode_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int LIMIT = 8,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] SAT = W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (tick && (cnt < SAT))
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwrseq_decode.sv
module pwrseq_decode #(
  parameter int T_TX = 11,
  parameter int T_RX = 22,
  parameter int T_DD = 26,
  parameter int MW   = 5
) (
  input  logic          run,
  input  logic          is_tx,
  input  logic [MW-1:0] mcnt,
  input  logic          sys_done,
  output logic          dcoc_en,
  output logic          pkdet_en,
  output logic          ddet_en,
  output logic          pa_en,
  output logic          seq_ready
);
  localparam logic [MW-1:0] LIM_TX = MW'(T_TX);
  localparam logic [MW-1:0] LIM_RX = MW'(T_RX);
  localparam logic [MW-1:0] LIM_DD = MW'(T_DD);

  logic rx_run, tx_run, last_up;

  always_comb begin
    tx_run    = run && is_tx;
    rx_run    = run && !is_tx;
    pa_en     = tx_run && (mcnt >= LIM_TX);
    dcoc_en   = rx_run;
    pkdet_en  = rx_run && (mcnt >= LIM_RX);
    ddet_en   = rx_run && (mcnt >= LIM_DD);
    last_up   = is_tx ? pa_en : ddet_en;
    seq_ready = last_up && sys_done;
  end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int T_CLK = 5,
  parameter int T_TX  = 11,
  parameter int T_RX  = 22,
  parameter int T_DD  = 26,
  parameter int T_SYS = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic mode_tx,
  input  logic keep_clk,
  input  logic tb_tick,
  output logic osc_en,
  output logic clkout_en,
  output logic dcoc_en,
  output logic pkdet_en,
  output logic ddet_en,
  output logic pa_en,
  output logic seq_ready
);
  localparam int MODE_MAX = imax(imax(T_TX, T_RX), T_DD);
  localparam int CW       = $clog2(T_CLK + 1);
  localparam int MW       = $clog2(MODE_MAX + 1);
  localparam int SW       = $clog2(T_SYS + 1);

  pwr_state_t  state_q;
  radio_mode_t mode_q;
  logic        first_q, sys_req_q;
  logic [CW-1:0] clk_cnt;
  logic [MW-1:0] mode_cnt;
  logic [SW-1:0] sys_cnt;
  logic osc_on, clk_ready, run, mode_restart, sys_done;

  // state register: follows the registered power-down pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SLEEP;
    else        state_q <= sleep_n ? ST_SLEEP : ST_RUN;
  end

  // the start path is chosen at the first edge after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q   <= 1'b1;
      sys_req_q <= 1'b0;
    end else if (first_q) begin
      first_q   <= 1'b0;
      sys_req_q <= !sleep_n;
    end
  end

  always_comb begin
    osc_on       = (state_q == ST_RUN) || keep_clk;
    clk_ready    = osc_on && (clk_cnt >= CW'(T_CLK));
    run          = (state_q == ST_RUN) && clk_ready;
    mode_restart = !run || (radio_mode_t'(mode_tx) != mode_q);
    sys_done     = !sys_req_q || (sys_cnt >= SW'(T_SYS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mode_q <= MODE_RX;
    else if (mode_restart) mode_q <= radio_mode_t'(mode_tx);
  end

  pwrseq_timer #(.LIMIT(T_CLK), .W(CW)) u_clk_tmr (
    .clk(clk), .rst_n(rst_n), .clr(!osc_on), .tick(tb_tick), .cnt(clk_cnt)
  );

  pwrseq_timer #(.LIMIT(MODE_MAX), .W(MW)) u_mode_tmr (
    .clk(clk), .rst_n(rst_n), .clr(mode_restart), .tick(tb_tick), .cnt(mode_cnt)
  );

  pwrseq_timer #(.LIMIT(T_SYS), .W(SW)) u_sys_tmr (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .tick(tb_tick), .cnt(sys_cnt)
  );

  pwrseq_decode #(.T_TX(T_TX), .T_RX(T_RX), .T_DD(T_DD), .MW(MW)) u_dec (
    .run(run), .is_tx(mode_q == MODE_TX), .mcnt(mode_cnt), .sys_done(sys_done),
    .dcoc_en(dcoc_en), .pkdet_en(pkdet_en), .ddet_en(ddet_en),
    .pa_en(pa_en), .seq_ready(seq_ready)
  );

  assign osc_en    = osc_on;
  assign clkout_en = clk_ready;
endmodule

// File: rtl/pwrseq_ctrl_chk.sv
module pwrseq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_n,
  input logic osc_en,
  input logic clkout_en,
  input logic dcoc_en,
  input logic pkdet_en,
  input logic ddet_en,
  input logic pa_en,
  input logic seq_ready
);
  assert_clk_needs_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_en |-> osc_en);
  assert_run_keeps_osc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> osc_en);
  assert_sleep_drops_modes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_n |=> !(dcoc_en || pkdet_en || ddet_en || pa_en || seq_ready));
  assert_pa_not_in_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pa_en |-> !dcoc_en);
  assert_pkdet_in_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkdet_en |-> dcoc_en);
  assert_ddet_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ddet_en |-> (pkdet_en && !pa_en));
  assert_clk_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_n && clkout_en) |=> clkout_en);
  assert_ready_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_ready |-> (pa_en || ddet_en));
endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .osc_en(osc_en),
  .clkout_en(clkout_en), .dcoc_en(dcoc_en), .pkdet_en(pkdet_en),
  .ddet_en(ddet_en), .pa_en(pa_en), .seq_ready(seq_ready)
);

// File: tb/test_pwrseq_ctrl.sv
`timescale 1ns/1ps
module test_pwrseq_ctrl;
  localparam int TC = 5, TT = 11, TR = 22, TD = 26, TS = 80;
  localparam int MMAX = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sleep_n = 1'b1, mode_tx = 1'b0, keep_clk = 1'b0, tb_tick = 1'b0;
  logic osc_en, clkout_en, dcoc_en, pkdet_en, ddet_en, pa_en, seq_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int  m_clk = 0, m_mcnt = 0, m_sys = 0;
  bit  m_act = 0, m_first = 1, m_req = 0, m_modeq = 0;

  always #2.5 clk = ~clk;

  pwrseq_ctrl #(.T_CLK(TC), .T_TX(TT), .T_RX(TR), .T_DD(TD), .T_SYS(TS)) i_pwrseq_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .mode_tx(mode_tx),
    .keep_clk(keep_clk), .tb_tick(tb_tick), .osc_en(osc_en), .clkout_en(clkout_en),
    .dcoc_en(dcoc_en), .pkdet_en(pkdet_en), .ddet_en(ddet_en), .pa_en(pa_en),
    .seq_ready(seq_ready)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  // time-base strobe: one pulse every four cycles, driven at the falling edge
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      tb_tick = 1'b1;
      @(negedge clk);
      tb_tick = 1'b0;
    end
  end

  // reference model updated on every rising edge, compared just after it
  always @(posedge clk) begin
    bit xon, crdy, run;
    if (!rst_n) begin
      m_act = 0; m_clk = 0; m_mcnt = 0; m_sys = 0;
      m_first = 1; m_req = 0; m_modeq = 0;
    end else begin
      xon  = m_act || keep_clk;
      crdy = xon && (m_clk >= TC);
      run  = m_act && crdy;
      if (!run || (mode_tx != m_modeq)) begin
        m_mcnt = 0;
        m_modeq = mode_tx;
      end else if (tb_tick && m_mcnt < MMAX) m_mcnt++;
      if (!xon) m_clk = 0;
      else if (tb_tick && m_clk < TC) m_clk++;
      if (tb_tick && m_sys < TS) m_sys++;
      if (m_first) begin m_req = !sleep_n; m_first = 0; end
      m_act = !sleep_n;
    end
    #1;
    if (!done) begin
      bit exon, ecrdy, erun, eready;
      exon  = m_act || keep_clk;
      ecrdy = exon && (m_clk >= TC);
      erun  = m_act && ecrdy;
      eready = erun && (!m_req || m_sys >= TS) &&
               (m_modeq ? (m_mcnt >= TT) : (m_mcnt >= TD));
      chk(osc_en,    exon,                            "R2 osc_en model");
      chk(clkout_en, ecrdy,                           "R3 clkout_en model");
      chk(pa_en,     erun && m_modeq && m_mcnt >= TT, "R5 pa_en model");
      chk(dcoc_en,   erun && !m_modeq,                "R6 dcoc_en model");
      chk(pkdet_en,  erun && !m_modeq && m_mcnt >= TR, "R6 pkdet_en model");
      chk(ddet_en,   erun && !m_modeq && m_mcnt >= TD, "R7 ddet_en model");
      chk(seq_ready, eready,                          "R9 seq_ready model");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // start in power-down
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk(osc_en, 1'b0, "R1 reset state osc");
    chk(clkout_en | dcoc_en | pa_en | seq_ready, 1'b0, "R1 reset state outputs");
    cyc(60);
    chk(osc_en | clkout_en, 1'b0, "R1 stays in power-down");
    // leave power-down into transmit
    mode_tx = 1'b1; sleep_n = 1'b0;
    cyc(200);
    chk(clkout_en, 1'b1, "R3 clock up");
    chk(pa_en, 1'b1, "R5 pa up in tx");
    chk(dcoc_en, 1'b0, "R5 no rx enable in tx");
    chk(seq_ready, 1'b1, "R9 ready without system delay");
    // direct switch to receive
    mode_tx = 1'b0;
    cyc(2);
    chk(pa_en, 1'b0, "R5 pa off in rx");
    chk(dcoc_en, 1'b1, "R6 dcoc at rx start");
    chk(pkdet_en, 1'b0, "R6 pkdet waits");
    chk(seq_ready, 1'b0, "R9 cleared on switch");
    chk(clkout_en, 1'b1, "R8 clock held on switch");
    cyc(200);
    chk(pkdet_en, 1'b1, "R6 pkdet up");
    chk(ddet_en, 1'b1, "R7 ddet up");
    chk(seq_ready, 1'b1, "R9 ready in rx");
    // back to power-down without the clock option
    sleep_n = 1'b1;
    cyc(1);
    chk(dcoc_en | ddet_en | seq_ready, 1'b0, "R4 modes dropped");
    chk(osc_en, 1'b0, "R4 osc dropped");
    // power-down with clock kept
    keep_clk = 1'b1;
    cyc(100);
    chk(osc_en, 1'b1, "R2 osc kept");
    chk(clkout_en, 1'b1, "R3 clock kept in power-down");
    chk(dcoc_en | pa_en, 1'b0, "R4 modes off while kept");
    // resume: no clock restart needed
    sleep_n = 1'b0; mode_tx = 1'b1;
    cyc(2);
    chk(clkout_en, 1'b1, "R8 clock immediately ready");
    cyc(100);
    chk(pa_en, 1'b1, "R5 pa up after resume");
    // reset straight into active transmit
    keep_clk = 1'b0;
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(120);
    chk(pa_en, 1'b1, "R5 pa up after active start");
    chk(seq_ready, 1'b0, "R9 system delay pending");
    cyc(300);
    chk(seq_ready, 1'b1, "R9 ready after system delay");
    cyc(5);
    finish_run();
  end
endmodule